// File: doc/BRIEF.md
# Vector Element Word Load Unit

This unit carries out one instruction kind: it loads a single 32-bit word from memory into one word lane of a 128-bit vector register. It takes a 32-bit instruction word and accepts two encodings. The narrow form can name 32 vector registers. The wide form builds a 7-bit destination index from two separate fields, so it can name all 128 registers. The unit reads two general-purpose operands and adds them to form the effective address. It then sends one read to memory. When the response arrives, it merges the returned data into its internal vector register file and pulses a done flag.

By default the word goes into the lane chosen by address bits [3:2], and the other three lanes keep their contents. When the full-line input is high at issue, the unit instead aligns the address down to 16 bytes and overwrites the whole register with the returned line. If the instruction word matches neither encoding, the unit flags it as illegal and does nothing else. A debug read port exposes any register of the file, so the result of a load can be observed.

Top module: `vec_elem_load`

## Requirements
- R1: A word is legal in the narrow form when `(instr & 0xFC0007FE) == 0x7C00008E`. In that form the destination register is instr[25:21] (registers 0 to 31), register A is instr[20:16] and register B is instr[15:11].
- R2: A word is legal in the wide form when `(instr & 0xFC0007F3) == 0x10000083`. In that form the destination index is {instr[3:2], instr[25:21]} (registers 0 to 127), and A and B sit in the same fields as in R1.
- R3: The effective address EA is the sum of base and GPR B, taken modulo 2^32. Base is GPR A, except that an A field of 0 selects the constant zero and not register 0. `gpr_a_val` and `gpr_b_val` carry the low 32 bits of the selected registers.
- R4: With `full_line_en` low at issue, the unit raises `mem_req` for exactly one cycle, in the cycle after the accepting edge. In that cycle `mem_addr` is EA with bits [1:0] cleared and `mem_line` is 0. `issue_ready` is low from that request until done.
- R5: In word mode the lane is EA[3:2]. Lane n occupies vector bits [127-32n : 96-32n], so lane 0 is the most significant word. The lane takes `mem_rsp_data[31:0]`, the other 96 response bits are ignored, and the other three lanes of the destination keep their values.
- R6: With `full_line_en` high at issue, `mem_addr` is EA with bits [3:0] cleared and `mem_line` is 1. The destination is replaced by all 128 bits of `mem_rsp_data`, where the byte at the lowest address is bits [127:120].
- R7: `done` is high for exactly one cycle, in the cycle after the edge that samples `mem_rsp_valid`. From that cycle on, the debug port shows the updated register.
- R8: A word that matches neither form sets `illegal` for one cycle after the accepting edge. It causes no memory request and changes no register.
- R9: After reset every vector register reads zero, `mem_req`, `done` and `illegal` are low, and `issue_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Unit idle and able to accept |
| instr | input | 32 | Instruction word |
| full_line_en | input | 1 | Full-line mode for this instruction |
| gpr_a_sel | output | 5 | A register number decoded from `instr` |
| gpr_b_sel | output | 5 | B register number decoded from `instr` |
| gpr_a_val | input | 32 | Low word of GPR `gpr_a_sel` |
| gpr_b_val | input | 32 | Low word of GPR `gpr_b_sel` |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Aligned read address |
| mem_line | output | 1 | 1 = 16-byte read, 0 = word read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 128 | Read data (word in bits [31:0]) |
| done | output | 1 | Write-back pulse |
| illegal | output | 1 | Unrecognised instruction pulse |
| dbg_idx | input | 7 | Debug read register index |
| dbg_data | output | 128 | Contents of register `dbg_idx` |

## Verification
The bench loads the same register several times in a row, each time at a different lane. A unit that cleared or shifted the neighbouring lanes would leave a register that no longer matches the accumulated expected value. It gives GPR 0 a nonzero value and uses an A field of 0, which catches a unit that adds register 0 instead of zero. It also uses an unaligned address and an address whose 64-bit sum overflows, which expose wrong masking or a wrong lane choice. It issues wide-form destinations such as 69 and 127 and then sweeps all 128 registers, which catches a swapped or dropped high index field. It also places junk in the unused response bits, issues line loads, and sends near-miss illegal words, each checked for a stray request or a register write.

// File: rtl/vel_pkg.sv
package vel_pkg;
   localparam logic [31:0] NARROW_MASK  = 32'hFC0007FE;
   localparam logic [31:0] NARROW_MATCH = 32'h7C00008E;
   localparam logic [31:0] WIDE_MASK    = 32'hFC0007F3;
   localparam logic [31:0] WIDE_MATCH   = 32'h10000083;
   localparam int          DST_W        = 7;

   typedef enum logic {ST_IDLE, ST_WAIT} vel_state_e;

   typedef struct packed {
      logic             legal;
      logic [DST_W-1:0] dst;
      logic [4:0]       ra;
      logic [4:0]       rb;
   } vel_dec_t;
endpackage

// File: rtl/vel_decode.sv
module vel_decode
   import vel_pkg::*;
(
   input  logic [31:0] instr,
   output vel_dec_t    dec
);
   logic is_narrow, is_wide;

   always_comb begin
      is_narrow = (instr & NARROW_MASK) == NARROW_MATCH;
      is_wide   = (instr & WIDE_MASK) == WIDE_MATCH;
      dec.legal = is_narrow | is_wide;
      dec.ra    = instr[20:16];
      dec.rb    = instr[15:11];
      dec.dst   = is_wide ? {instr[3:2], instr[25:21]} : {2'b00, instr[25:21]};
   end
endmodule

// File: rtl/vel_agen.sv
module vel_agen #(
   parameter int ADDR_W = 32,
   parameter int WORD_W = 32,
   parameter int LANES  = 4
) (
   input  logic                     ra_zero,
   input  logic [ADDR_W-1:0]        a_val,
   input  logic [ADDR_W-1:0]        b_val,
   input  logic                     line_mode,
   output logic [ADDR_W-1:0]        addr,
   output logic [$clog2(LANES)-1:0] lane
);
   localparam int WB = $clog2(WORD_W / 8);
   localparam int LB = WB + $clog2(LANES);
   localparam logic [ADDR_W-1:0] WORD_KEEP = ~((ADDR_W'(1) << WB) - ADDR_W'(1));
   localparam logic [ADDR_W-1:0] LINE_KEEP = ~((ADDR_W'(1) << LB) - ADDR_W'(1));

   logic [ADDR_W-1:0] ea;

   always_comb begin
      ea   = (ra_zero ? '0 : a_val) + b_val;
      addr = ea & (line_mode ? LINE_KEEP : WORD_KEEP);
      lane = ea[LB-1:WB];
   end
endmodule

// File: rtl/vel_merge.sv
module vel_merge #(
   parameter int WORD_W = 32,
   parameter int LANES  = 4
) (
   input  logic [WORD_W*LANES-1:0]  old_row,
   input  logic [WORD_W*LANES-1:0]  rsp,
   input  logic [$clog2(LANES)-1:0] lane,
   input  logic                     line_mode,
   output logic [WORD_W*LANES-1:0]  new_row
);
   localparam int LANE_IW = $clog2(LANES);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int TOP = (LANES - g) * WORD_W - 1;
      always_comb begin
         if (line_mode)
            new_row[TOP -: WORD_W] = rsp[TOP -: WORD_W];
         else if (lane == LANE_IW'(g))
            new_row[TOP -: WORD_W] = rsp[WORD_W-1:0];
         else
            new_row[TOP -: WORD_W] = old_row[TOP -: WORD_W];
      end
   end
endmodule

// File: rtl/vec_elem_load.sv
module vec_elem_load
   import vel_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int WORD_W = 32,
   parameter int LANES  = 4,
   parameter int VREG_N = 128
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       issue_valid,
   output logic                       issue_ready,
   input  logic [31:0]                instr,
   input  logic                       full_line_en,
   output logic [4:0]                 gpr_a_sel,
   output logic [4:0]                 gpr_b_sel,
   input  logic [ADDR_W-1:0]          gpr_a_val,
   input  logic [ADDR_W-1:0]          gpr_b_val,
   output logic                       mem_req,
   output logic [ADDR_W-1:0]          mem_addr,
   output logic                       mem_line,
   input  logic                       mem_rsp_valid,
   input  logic [WORD_W*LANES-1:0]    mem_rsp_data,
   output logic                       done,
   output logic                       illegal,
   input  logic [$clog2(VREG_N)-1:0]  dbg_idx,
   output logic [WORD_W*LANES-1:0]    dbg_data
);
   localparam int VEC_W   = WORD_W * LANES;
   localparam int VIDX_W  = $clog2(VREG_N);
   localparam int LANE_IW = $clog2(LANES);

   if (WORD_W % 8 != 0) begin : g_chk_word
      $error("WORD_W must be a whole number of bytes");
   end
   if (LANES < 2 || (1 << LANE_IW) != LANES) begin : g_chk_lanes
      $error("LANES must be a power of two, at least 2");
   end
   if (VREG_N < (1 << DST_W)) begin : g_chk_vregs
      $error("VREG_N must cover the 7-bit destination index");
   end
   if (ADDR_W < $clog2(VEC_W / 8)) begin : g_chk_addr
      $error("ADDR_W too narrow for line alignment");
   end

   vel_state_e           state;
   vel_dec_t             dec;
   logic [ADDR_W-1:0]    ag_addr;
   logic [LANE_IW-1:0]   ag_lane;
   logic [VIDX_W-1:0]    dst_q;
   logic [LANE_IW-1:0]   lane_q;
   logic [VEC_W-1:0]     merged;
   logic [VEC_W-1:0]     vrf [VREG_N];

   vel_decode u_dec (.instr(instr), .dec(dec));

   vel_agen #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANES(LANES)) u_agen (
      .ra_zero  (dec.ra == 5'd0),
      .a_val    (gpr_a_val),
      .b_val    (gpr_b_val),
      .line_mode(full_line_en),
      .addr     (ag_addr),
      .lane     (ag_lane)
   );

   vel_merge #(.WORD_W(WORD_W), .LANES(LANES)) u_merge (
      .old_row  (vrf[dst_q]),
      .rsp      (mem_rsp_data),
      .lane     (lane_q),
      .line_mode(mem_line),
      .new_row  (merged)
   );

   assign gpr_a_sel   = dec.ra;
   assign gpr_b_sel   = dec.rb;
   assign issue_ready = (state == ST_IDLE);
   assign dbg_data    = vrf[dbg_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         mem_req  <= 1'b0;
         mem_addr <= '0;
         mem_line <= 1'b0;
         done     <= 1'b0;
         illegal  <= 1'b0;
         dst_q    <= '0;
         lane_q   <= '0;
         for (int i = 0; i < VREG_N; i++) vrf[i] <= '0;
      end else begin
         mem_req <= 1'b0;
         done    <= 1'b0;
         illegal <= 1'b0;
         case (state)
            ST_IDLE: if (issue_valid) begin
               if (dec.legal) begin
                  dst_q    <= VIDX_W'(dec.dst);
                  lane_q   <= ag_lane;
                  mem_addr <= ag_addr;
                  mem_line <= full_line_en;
                  mem_req  <= 1'b1;
                  state    <= ST_WAIT;
               end else begin
                  illegal <= 1'b1;
               end
            end
            ST_WAIT: if (mem_rsp_valid) begin
               vrf[dst_q] <= merged;
               done       <= 1'b1;
               state      <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/vel_checker.sv
module vel_checker #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue_ready,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_line,
   input logic              mem_rsp_valid,
   input logic              done,
   input logic              illegal
);
   assert_req_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   assert_req_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !issue_ready);

   assert_word_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_line) |-> (mem_addr[1:0] == 2'b00));

   assert_line_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_line) |-> (mem_addr[3:0] == 4'h0));

   assert_done_after_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rsp_valid && !issue_ready) |=> done);

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_illegal_noreq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!mem_req && issue_ready));
endmodule

bind vec_elem_load vel_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .issue_ready  (issue_ready),
   .mem_req      (mem_req),
   .mem_addr     (mem_addr),
   .mem_line     (mem_line),
   .mem_rsp_valid(mem_rsp_valid),
   .done         (done),
   .illegal      (illegal)
);

// File: tb/vec_elem_load_bench.sv
`timescale 1ns/1ps
module vec_elem_load_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         issue_valid = 1'b0;
   logic         issue_ready;
   logic [31:0]  instr = '0;
   logic         full_line_en = 1'b0;
   logic [4:0]   gpr_a_sel, gpr_b_sel;
   logic [31:0]  gpr_a_val, gpr_b_val;
   logic         mem_req;
   logic [31:0]  mem_addr;
   logic         mem_line;
   logic         mem_rsp_valid = 1'b0;
   logic [127:0] mem_rsp_data = '0;
   logic         done, illegal;
   logic [6:0]   dbg_idx = '0;
   logic [127:0] dbg_data;

   logic [63:0]  bgpr [32];
   logic [127:0] model [128];

   typedef struct {
      logic         ill;
      logic [31:0]  addr;
      logic         line;
      logic [6:0]   dst;
      logic [127:0] row;
   } item_t;
   item_t q[$];

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   assign gpr_a_val = bgpr[gpr_a_sel][31:0];
   assign gpr_b_val = bgpr[gpr_b_sel][31:0];

   vec_elem_load u_vec_elem_load (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
      .instr(instr), .full_line_en(full_line_en),
      .gpr_a_sel(gpr_a_sel), .gpr_b_sel(gpr_b_sel),
      .gpr_a_val(gpr_a_val), .gpr_b_val(gpr_b_val),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_line(mem_line),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done(done), .illegal(illegal), .dbg_idx(dbg_idx), .dbg_data(dbg_data)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] mbyte(input logic [31:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
   endfunction

   function automatic logic [31:0] narrow(input logic [4:0] d, input logic [4:0] a,
                                          input logic [4:0] b);
      return 32'h7C00008E | (32'(d) << 21) | (32'(a) << 16) | (32'(b) << 11);
   endfunction

   function automatic logic [31:0] wide(input logic [6:0] d, input logic [4:0] a,
                                        input logic [4:0] b);
      return 32'h10000083 | (32'(d[4:0]) << 21) | (32'(a) << 16) | (32'(b) << 11)
             | (32'(d[6:5]) << 2);
   endfunction

   // Driver: computes the expected result from the requirements and queues it
   task automatic issue(input logic [31:0] w, input logic fl);
      item_t it;
      logic [63:0] base, ea64;
      logic [31:0] ea;
      int lane;
      bit nar, wid;
      nar = (w & 32'hFC0007FE) == 32'h7C00008E;
      wid = (w & 32'hFC0007F3) == 32'h10000083;
      it.ill = !(nar || wid);
      it.dst = wid ? {w[3:2], w[25:21]} : {2'b00, w[25:21]};
      base = (w[20:16] == 5'd0) ? 64'd0 : bgpr[w[20:16]];
      ea64 = base + bgpr[w[15:11]];
      ea = ea64[31:0];
      it.line = fl;
      it.addr = fl ? (ea & 32'hFFFFFFF0) : (ea & 32'hFFFFFFFC);
      it.row = '0;
      if (!it.ill) begin
         it.row = model[it.dst];
         if (fl) begin
            for (int i = 0; i < 16; i++) it.row[127-8*i -: 8] = mbyte(it.addr + 32'(i));
         end else begin
            lane = int'(ea[3:2]);
            for (int i = 0; i < 4; i++) it.row[127-32*lane-8*i -: 8] = mbyte(it.addr + 32'(i));
         end
         model[it.dst] = it.row;
      end
      q.push_back(it);
      @(negedge clk);
      while (!issue_ready) @(negedge clk);
      instr = w;
      full_line_en = fl;
      issue_valid = 1'b1;
      @(negedge clk);
      issue_valid = 1'b0;
      if (it.ill) chk(illegal == 1'b1 && mem_req == 1'b0, "R8", {126'd0, illegal, mem_req}, 128'd2);
      else chk(mem_req == 1'b1, "R4", 128'(mem_req), 128'd1);
      while (q.size() != 0) @(negedge clk);
   endtask

   // Monitor: memory responder and scoreboard comparison
   initial begin
      item_t it;
      bit expect_done;
      logic [127:0] d;
      expect_done = 0;
      forever begin
         @(negedge clk);
         if (!rst_n) continue;
         if (expect_done) begin
            expect_done = 0;
            mem_rsp_valid = 1'b0;
            chk(done == 1'b1, "R7", 128'(done), 128'd1);
            if (done && q.size() != 0) begin
               it = q.pop_front();
               dbg_idx = it.dst;
               #1;
               chk(dbg_data == it.row, it.line ? "R6" : "R5", dbg_data, it.row);
            end
         end else if (done) begin
            chk(1'b0, "R7", 128'd1, 128'd0);
         end
         if (mem_req) begin
            if (q.size() == 0 || q[0].ill) begin
               chk(1'b0, "R8", 128'(mem_addr), 128'd0);
            end else begin
               chk(mem_addr == q[0].addr, q[0].line ? "R6" : "R4", 128'(mem_addr), 128'(q[0].addr));
               chk(mem_line == q[0].line && !issue_ready, "R4",
                   {126'd0, mem_line, issue_ready}, {126'd0, q[0].line, 1'b0});
            end
            d = {96'hFFFF_FFFF_0000_FFFF_A5A5_5A5A, 32'h0};
            if (mem_line) begin
               for (int i = 0; i < 16; i++) d[127-8*i -: 8] = mbyte(mem_addr + 32'(i));
            end else begin
               for (int i = 0; i < 4; i++) d[31-8*i -: 8] = mbyte(mem_addr + 32'(i));
            end
            mem_rsp_data = d;
            mem_rsp_valid = 1'b1;
            expect_done = 1;
         end
         if (illegal) begin
            if (q.size() != 0) begin
               it = q.pop_front();
               chk(it.ill == 1'b1, "R8", 128'd1, 128'(it.ill));
            end else begin
               chk(1'b0, "R8", 128'd1, 128'd0);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog act=hung exp=complete");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 32; i++) bgpr[i] = 64'h0000_0001_0000_0000 * i + 64'(i * 16'h0110);
      for (int i = 0; i < 128; i++) model[i] = '0;
      bgpr[0] = 64'h0000_0000_0000_7770;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      chk(issue_ready && !mem_req && !done && !illegal, "R9",
          {124'd0, issue_ready, mem_req, done, illegal}, 128'h8);
      dbg_idx = 7'd5;   #1; chk(dbg_data == '0, "R9", dbg_data, '0);
      dbg_idx = 7'd127; #1; chk(dbg_data == '0, "R9", dbg_data, '0);

      // R1 R5: lanes 1, 2, 3 of one register, accumulating
      bgpr[1] = 64'h0000_0000_0000_1000; bgpr[2] = 64'h4;
      issue(narrow(5'd3, 5'd1, 5'd2), 1'b0);
      // R3: A field zero uses constant zero, not GPR 0
      bgpr[4] = 64'h0000_0000_0000_2008;
      issue(narrow(5'd3, 5'd0, 5'd4), 1'b0);
      // R4: unaligned address, lane 3
      bgpr[6] = 64'h0000_0000_0000_300F;
      issue(narrow(5'd3, 5'd0, 5'd6), 1'b0);
      // R3: 64-bit sum wraps, low word kept
      bgpr[7] = 64'hFFFF_FFFF_FFFF_FFF0; bgpr[8] = 64'h20;
      issue(narrow(5'd3, 5'd7, 5'd8), 1'b0);
      // R1: Rc bit set is still the narrow form, register 31
      issue(narrow(5'd31, 5'd1, 5'd2) | 32'h1, 1'b0);
      // R2: wide form, split destination index
      issue(wide(7'd127, 5'd1, 5'd6), 1'b0);
      issue(wide(7'd69, 5'd7, 5'd4), 1'b0);
      issue(wide(7'd37, 5'd0, 5'd2), 1'b0);
      // R6: full-line loads
      bgpr[9] = 64'h0000_0000_0000_3007;
      issue(narrow(5'd10, 5'd0, 5'd9), 1'b1);
      issue(wide(7'd100, 5'd1, 5'd9), 1'b1);
      // R5: word load after a line load keeps the other lanes
      issue(narrow(5'd10, 5'd0, 5'd6), 1'b0);
      // R8: near misses and junk
      issue(32'h7C000090, 1'b0);
      issue(32'h10000093, 1'b0);
      issue(32'h00000000, 1'b1);
      issue(32'h7C00008E | 32'h0400_0000 ^ 32'h0400_0000 | 32'h8000_0000, 1'b0);
      // R8: no register changed beyond the expected writes
      for (int i = 0; i < 128; i++) begin
         dbg_idx = 7'(i);
         #1;
         chk(dbg_data == model[i], "R8", dbg_data, model[i]);
      end
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule